// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block runs the entry sequence of a small 8-bit processor core when that core takes a hardware interrupt or a software break. When it starts, it captures the current 16-bit program counter, the status byte and the 8-bit stack pointer. It then pushes three bytes through a byte-wide memory bus into the fixed stack page: the high half of the return address, the low half, and then the status byte. After the pushes it reads the two-byte handler vector. When the sequence ends, it presents the new program counter, the updated stack pointer and a one-cycle request to set the interrupt-disable flag.

Three sources can start an entry. IRQ is level-sensitive and active low, and the interrupt-disable flag masks it. NMI triggers on a falling edge, and the block holds it pending until it is serviced. A break request starts a software entry. The block chooses the vector when it reads the vector, not when it starts. As a result, an NMI that arrives while the block is pushing the bytes of a break or an IRQ redirects that entry to the NMI handler. The break bit that the block already decided for the pushed status stays as it is.

The memory bus is assumed to answer a read in the same cycle. Decode, the ALU and the return path are outside this block.

Top module: `irq_entry_seq`

## Requirements
- R1: Each push writes address 0x0100 + stack pointer. The pointer starts at the captured `sp_in` and decrements by one after each write, wrapping within 8 bits. For example, sp 0x01 writes 0x0101, then 0x0100, then 0x01FF.
- R2: Exactly three writes happen per entry, in this order: PC[15:8], then PC[7:0], then the status byte. Reads and writes never occur in the same cycle.
- R3: The pushed status equals `status_in` except for two bits. Bit 5 is forced to 1. Bit 4 is 1 for an entry started by `brk_req` and 0 for an entry started by IRQ or NMI.
- R4: An IRQ or break entry reads 0xFFFE (low byte) and then 0xFFFF (high byte), and `pc_out` = {byte at 0xFFFF, byte at 0xFFFE}.
- R5: An NMI entry reads 0xFFFA and then 0xFFFB, and `pc_out` = {byte at 0xFFFB, byte at 0xFFFA}.
- R6: If an NMI is pending when an in-progress entry reaches its vector read, that entry uses the NMI vector (R5) and consumes the NMI. A break entry taken over in this way still pushes bit 4 = 1.
- R7: While `i_flag` = 1, a low `irq_n` starts no entry: there are no bus accesses and `busy` stays 0.
- R8: At the end of each entry, `done` and `set_i` are 1 for exactly one cycle. In that cycle `pc_out` holds the vector and `sp_out` = `sp_in` − 3 (mod 256). After that cycle the block is idle.
- R9: A falling edge on `nmi_n` is latched, even while another entry is busy, and is serviced exactly once. Holding `nmi_n` low does not start another entry.
- R10: IRQ is active low: with `irq_n` = 1 and nothing else requested, no entry starts.
- R11: After synchronous reset the block is idle: `busy`, `done`, `set_i`, `mem_we` and `mem_re` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Level-sensitive interrupt request, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge triggered |
| brk_req | input | 1 | Software break request, sampled while idle |
| i_flag | input | 1 | Interrupt-disable flag from the core |
| pc_in | input | 16 | Current program counter (return address) |
| status_in | input | 8 | Current status byte |
| sp_in | input | 8 | Current stack pointer |
| mem_addr | output | 16 | Memory bus address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the cycle of `mem_re` |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle end-of-entry pulse |
| pc_out | output | 16 | Handler address, valid while `done` |
| sp_out | output | 8 | Updated stack pointer |
| set_i | output | 1 | Request to set the interrupt-disable flag |

## Verification
The hardest case to reach is the takeover, where an NMI edge lands while a break is still pushing its bytes. The edge has to fall after the entry has started but before the vector read. The break test therefore pulls `nmi_n` low in the first push cycle, which the bench recognises by the first write strobe. It then checks both the NMI vector reads and the break bit in the third pushed byte. A second timing-sensitive case is an NMI pulse during the high vector read of an IRQ entry. That edge must not affect the current entry, and it must produce exactly one later NMI entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int SPW = 8;

    localparam logic [DW-1:0] STACK_PAGE = 8'h01;
    localparam logic [AW-1:0] VEC_NMI    = 16'hFFFA;
    localparam logic [AW-1:0] VEC_IRQ    = 16'hFFFE;

    localparam int BRK_BIT = 4;
    localparam int ONE_BIT = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_PUSH_P,
        ST_VEC_L,
        ST_VEC_H,
        ST_DONE
    } entry_state_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [DW-1:0] status;
        logic          is_brk;
    } entry_ctx_t;

    typedef struct packed {
        logic          we;
        logic          re;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    function automatic logic [AW-1:0] stack_addr(input logic [SPW-1:0] sp);
        return {STACK_PAGE, sp};
    endfunction

    function automatic logic [DW-1:0] pushed_status(input logic [DW-1:0] s,
                                                    input logic brk);
        logic [DW-1:0] r;
        r = s;
        r[ONE_BIT] = 1'b1;
        r[BRK_BIT] = brk;
        return r;
    endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic consume,
    output logic pending
);
    logic nmi_q;
    logic fall;

    assign fall = nmi_q & ~nmi_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q   <= 1'b1;
            pending <= 1'b0;
        end else begin
            nmi_q <= nmi_n;
            // a new edge wins over the consume of an older one
            if (fall)
                pending <= 1'b1;
            else if (consume)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            start_brk,
    input  logic [AW-1:0]   pc_in,
    input  logic [DW-1:0]   status_in,
    input  logic [SPW-1:0]  sp_in,
    input  logic            nmi_pend,
    input  logic [DW-1:0]   vec_rdata,
    output entry_state_t    state,
    output entry_ctx_t      ctx,
    output logic [SPW-1:0]  sp,
    output logic            vec_nmi,
    output logic [AW-1:0]   pc_out,
    output logic            consume
);
    entry_state_t  nxt;
    logic [DW-1:0] vec_lo;

    assign consume = (state == ST_VEC_L) && nmi_pend;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_PUSH_H;
            ST_PUSH_H: nxt = ST_PUSH_L;
            ST_PUSH_L: nxt = ST_PUSH_P;
            ST_PUSH_P: nxt = ST_VEC_L;
            ST_VEC_L:  nxt = ST_VEC_H;
            ST_VEC_H:  nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctx     <= '0;
            sp      <= '0;
            vec_nmi <= 1'b0;
            vec_lo  <= '0;
            pc_out  <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: if (start) begin
                    ctx.pc     <= pc_in;
                    ctx.status <= status_in;
                    ctx.is_brk <= start_brk;
                    sp         <= sp_in;
                end
                ST_PUSH_H, ST_PUSH_L, ST_PUSH_P: sp <= sp - 1'b1;
                ST_VEC_L: begin
                    vec_nmi <= nmi_pend;
                    vec_lo  <= vec_rdata;
                end
                ST_VEC_H: pc_out <= {vec_rdata, vec_lo};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_bus_mux.sv
module irq_bus_mux
    import irq_entry_pkg::*;
(
    input  entry_state_t   state,
    input  entry_ctx_t     ctx,
    input  logic [SPW-1:0] sp,
    input  logic           nmi_pend,
    input  logic           vec_nmi,
    output bus_req_t       bus
);
    logic [AW-1:0] vec_base_now;
    logic [AW-1:0] vec_base_held;

    assign vec_base_now  = nmi_pend ? VEC_NMI : VEC_IRQ;
    assign vec_base_held = vec_nmi  ? VEC_NMI : VEC_IRQ;

    always_comb begin
        bus = '0;
        unique case (state)
            ST_PUSH_H: begin
                bus.we = 1'b1; bus.addr = stack_addr(sp);
                bus.wdata = ctx.pc[AW-1:DW];
            end
            ST_PUSH_L: begin
                bus.we = 1'b1; bus.addr = stack_addr(sp);
                bus.wdata = ctx.pc[DW-1:0];
            end
            ST_PUSH_P: begin
                bus.we = 1'b1; bus.addr = stack_addr(sp);
                bus.wdata = pushed_status(ctx.status, ctx.is_brk);
            end
            ST_VEC_L: begin
                bus.re = 1'b1; bus.addr = vec_base_now;
            end
            ST_VEC_H: begin
                bus.re = 1'b1; bus.addr = vec_base_held | 16'h0001;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         irq_n,
    input  logic         nmi_n,
    input  logic         brk_req,
    input  logic         i_flag,
    input  logic [15:0]  pc_in,
    input  logic [7:0]   status_in,
    input  logic [7:0]   sp_in,
    output logic [15:0]  mem_addr,
    output logic [7:0]   mem_wdata,
    output logic         mem_we,
    output logic         mem_re,
    input  logic [7:0]   mem_rdata,
    output logic         busy,
    output logic         done,
    output logic [15:0]  pc_out,
    output logic [7:0]   sp_out,
    output logic         set_i
);
    entry_state_t   state;
    entry_ctx_t     ctx;
    bus_req_t       bus;
    logic [SPW-1:0] sp;
    logic           nmi_pend;
    logic           consume;
    logic           vec_nmi;
    logic           start;

    assign start = (state == ST_IDLE) &&
                   (brk_req || nmi_pend || (!irq_n && !i_flag));

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_n   (nmi_n),
        .consume (consume),
        .pending (nmi_pend)
    );

    irq_entry_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_brk (brk_req),
        .pc_in     (pc_in),
        .status_in (status_in),
        .sp_in     (sp_in),
        .nmi_pend  (nmi_pend),
        .vec_rdata (mem_rdata),
        .state     (state),
        .ctx       (ctx),
        .sp        (sp),
        .vec_nmi   (vec_nmi),
        .pc_out    (pc_out),
        .consume   (consume)
    );

    irq_bus_mux u_bus (
        .state    (state),
        .ctx      (ctx),
        .sp       (sp),
        .nmi_pend (nmi_pend),
        .vec_nmi  (vec_nmi),
        .bus      (bus)
    );

    assign mem_addr  = bus.addr;
    assign mem_wdata = bus.wdata;
    assign mem_we    = bus.we;
    assign mem_re    = bus.re;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign set_i     = (state == ST_DONE);
    assign sp_out    = sp;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_we,
    input logic        mem_re,
    input logic        done,
    input logic        busy
);
    assert_stack_page_R1: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[15:8] == 8'h01);

    assert_sp_step_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1);

    assert_one_access_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    assert_status_bit5_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we) && $past(mem_we, 2)) |-> mem_wdata[5]);

    assert_vector_zone_R4: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> (mem_addr[15:3] == 13'h1FFF && mem_addr[1]));

    assert_done_after_read_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_re));

    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .done      (done),
    .busy      (busy)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_n = 1'b1, nmi_n = 1'b1, brk_req = 1'b0, i_flag = 1'b0;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  status_in = 8'h00, sp_in = 8'hFF;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, mem_rdata, sp_out;
    logic        mem_we, mem_re, busy, done, set_i;

    int errors = 0;
    int checks = 0;
    int wcnt = 0;
    int rcnt = 0;
    logic [15:0] waddr [0:255];
    logic [7:0]  wdat  [0:255];
    logic [15:0] raddr [0:255];

    always #10 clk = ~clk;

    // vector bytes: NMI -> 0x1234, IRQ/BRK -> 0x5678
    assign mem_rdata = (mem_addr == 16'hFFFA) ? 8'h34 :
                       (mem_addr == 16'hFFFB) ? 8'h12 :
                       (mem_addr == 16'hFFFE) ? 8'h78 :
                       (mem_addr == 16'hFFFF) ? 8'h56 : 8'h00;

    irq_entry_seq dut (
        .clk(clk), .rst(rst), .irq_n(irq_n), .nmi_n(nmi_n), .brk_req(brk_req),
        .i_flag(i_flag), .pc_in(pc_in), .status_in(status_in), .sp_in(sp_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .pc_out(pc_out), .sp_out(sp_out), .set_i(set_i)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            waddr[wcnt % 256] <= mem_addr;
            wdat[wcnt % 256]  <= mem_wdata;
            wcnt <= wcnt + 1;
        end
        if (mem_re) begin
            raddr[rcnt % 256] <= mem_addr;
            rcnt <= rcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    task automatic verify(input int w0, input int r0, input logic [7:0] sp0,
                          input logic [15:0] pc, input logic [7:0] st_exp,
                          input logic [15:0] vbase, input logic [15:0] vval,
                          input string tag);
        chk(wcnt - w0 == 3, {tag, " R2 write count"}, wcnt - w0, 3);
        chk(waddr[w0 % 256] == {8'h01, sp0}, {tag, " R1 addr0"},
            waddr[w0 % 256], {8'h01, sp0});
        chk(waddr[(w0+1) % 256] == {8'h01, sp0 - 8'd1}, {tag, " R1 addr1"},
            waddr[(w0+1) % 256], {8'h01, sp0 - 8'd1});
        chk(waddr[(w0+2) % 256] == {8'h01, sp0 - 8'd2}, {tag, " R1 addr2"},
            waddr[(w0+2) % 256], {8'h01, sp0 - 8'd2});
        chk(wdat[w0 % 256] == pc[15:8], {tag, " R2 PCH"}, wdat[w0 % 256], pc[15:8]);
        chk(wdat[(w0+1) % 256] == pc[7:0], {tag, " R2 PCL"}, wdat[(w0+1) % 256], pc[7:0]);
        chk(wdat[(w0+2) % 256] == st_exp, {tag, " R3 status"}, wdat[(w0+2) % 256], st_exp);
        chk(raddr[r0 % 256] == vbase, {tag, " R4/R5 vec lo addr"}, raddr[r0 % 256], vbase);
        chk(raddr[(r0+1) % 256] == (vbase | 16'h1), {tag, " R4/R5 vec hi addr"},
            raddr[(r0+1) % 256], vbase | 16'h1);
        chk(pc_out == vval, {tag, " R8 pc_out"}, pc_out, vval);
        chk(sp_out == sp0 - 8'd3, {tag, " R8 sp_out"}, sp_out, sp0 - 8'd3);
        chk(set_i == 1'b1, {tag, " R8 set_i"}, set_i, 1);
        @(negedge clk);
        chk(!busy && !done && !set_i, {tag, " R8 idle after done"}, busy, 0);
    endtask

    task automatic quiet(input int n, input string tag);
        int w0 = wcnt;
        int r0 = rcnt;
        bit active = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy) active = 1;
        end
        chk(!active && wcnt == w0 && rcnt == r0, tag, wcnt - w0, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(!busy && !done && !set_i && !mem_we && !mem_re, "R11 reset idle",
            {busy, done, set_i, mem_we, mem_re}, 0);
    endtask

    task automatic test_irq_high();
        i_flag = 0; irq_n = 1;
        quiet(10, "R10 irq_n high no entry");
    endtask

    task automatic test_irq_masked();
        i_flag = 1; irq_n = 0;
        quiet(10, "R7 masked irq ignored");
        irq_n = 1; i_flag = 0;
    endtask

    task automatic test_irq(input logic [7:0] sp0, input string tag);
        int w0 = wcnt;
        int r0 = rcnt;
        bit seen;
        pc_in = 16'hC123; status_in = 8'hC3; sp_in = sp0; i_flag = 0;
        irq_n = 0;
        wait_done(seen);
        chk(seen, {tag, " R8 done seen"}, seen, 1);
        i_flag = 1;
        // R3: 0xC3 with bit5 set, bit4 clear -> 0xE3
        if (seen) verify(w0, r0, sp0, 16'hC123, 8'hE3, 16'hFFFE, 16'h5678, tag);
        irq_n = 1; i_flag = 0;
        @(negedge clk);
    endtask

    task automatic test_brk();
        int w0 = wcnt;
        int r0 = rcnt;
        bit seen;
        pc_in = 16'h8002; status_in = 8'h00; sp_in = 8'hF0;
        brk_req = 1;
        @(negedge clk);
        brk_req = 0;
        wait_done(seen);
        chk(seen, "R3 brk done seen", seen, 1);
        // R3: bit5 and bit4 set -> 0x30; R4 vector
        if (seen) verify(w0, r0, 8'hF0, 16'h8002, 8'h30, 16'hFFFE, 16'h5678, "brk R4");
    endtask

    task automatic test_nmi();
        int w0 = wcnt;
        int r0 = rcnt;
        bit seen;
        pc_in = 16'h4455; status_in = 8'h1C; sp_in = 8'h80; i_flag = 1;
        nmi_n = 0;
        wait_done(seen);
        chk(seen, "R5 nmi done seen", seen, 1);
        // R3: 0x1C -> bit5 set, bit4 clear -> 0x2C
        if (seen) verify(w0, r0, 8'h80, 16'h4455, 8'h2C, 16'hFFFA, 16'h1234, "nmi R5");
        quiet(12, "R9 held nmi_n low no retrigger");
        nmi_n = 1; i_flag = 0;
        @(negedge clk);
    endtask

    task automatic test_hijack();
        int w0 = wcnt;
        int r0 = rcnt;
        bit seen;
        pc_in = 16'h0A0B; status_in = 8'h01; sp_in = 8'h40; i_flag = 1;
        brk_req = 1;
        @(negedge clk);
        brk_req = 0;
        chk(mem_we, "R6 first push cycle reached", mem_we, 1);
        nmi_n = 0;
        wait_done(seen);
        chk(seen, "R6 hijack done seen", seen, 1);
        // R6: NMI vector, bit4 kept -> 0x01|0x30 = 0x31
        if (seen) verify(w0, r0, 8'h40, 16'h0A0B, 8'h31, 16'hFFFA, 16'h1234, "hijack R6");
        nmi_n = 1;
        quiet(8, "R6 nmi consumed by hijacked entry");
        i_flag = 0;
    endtask

    task automatic test_nmi_during_busy();
        int w0, r0;
        bit seen, hit;
        pc_in = 16'h2222; status_in = 8'h00; sp_in = 8'h10; i_flag = 0;
        w0 = wcnt; r0 = rcnt;
        irq_n = 0;
        hit = 0;
        for (int i = 0; i < 20 && !hit; i++) begin
            @(negedge clk);
            if (mem_re && mem_addr[0]) hit = 1;
        end
        chk(hit, "R9 reached high vector read", hit, 1);
        nmi_n = 0;
        wait_done(seen);
        i_flag = 1; irq_n = 1;
        if (seen) verify(w0, r0, 8'h10, 16'h2222, 8'h20, 16'hFFFE, 16'h5678, "irq R9");
        nmi_n = 1;
        w0 = wcnt; r0 = rcnt;
        sp_in = 8'h0D;
        wait_done(seen);
        chk(seen, "R9 latched nmi serviced", seen, 1);
        if (seen) verify(w0, r0, 8'h0D, 16'h2222, 8'h20, 16'hFFFA, 16'h1234, "late nmi R9");
        quiet(8, "R9 latched nmi serviced once");
        i_flag = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        test_reset();
        test_irq_high();
        test_irq_masked();
        test_irq(8'hFF, "irq R4");
        test_irq(8'h01, "wrap R1");
        test_brk();
        test_nmi();
        test_hijack();
        test_nmi_during_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule